// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block handles the receive-side descriptor handling of an Ethernet MAC. Memory holds a ring of two-word descriptors that starts at `ring_base`. Each descriptor has an address word and a status word. In the address word, bits 31:2 give a word-aligned buffer pointer. Bit 0 is the ownership flag: the engine may use the descriptor only while this bit is 0. Bit 1 is the wrap flag: it sends the engine back to the ring base after this descriptor. The status word, at descriptor address + 4, receives the frame length and the address-match classification.

When a frame begins (`frm_start`), the engine reads the current address word. If the descriptor is free, it presents the buffer pointer on `buf_addr` with a one-cycle `buf_valid`. If the descriptor is still owned, it drops the frame and raises buffer-not-available. When the frame ends (`frm_end`), the engine writes the status word, then writes the address word back with the ownership bit set, and then steps to the next descriptor. Three sticky flags report frame received, buffer not available and overrun, and software clears each flag separately. Dropping `rx_enable` aborts any work in progress and returns the engine to the ring base; this is how software recovers after buffer-not-available.

The memory port is a plain request/acknowledge interface: a request is held until a one-cycle acknowledge, and read data arrives with that acknowledge.

Top module: `rxring_engine`

## Requirements
- R1: After reset, `busy`, `mem_req`, `buf_valid`, `frm_drop` and all three status flags are 0.
- R2: A `frm_start` pulse while `rx_enable` is 1 and the engine is idle starts a read request (`mem_we`=0) of the address word at `desc_ptr`.
- R3: If bit 0 of the fetched address word is 0, `buf_valid` pulses for one cycle with `buf_addr` equal to the word ANDed with 0xFFFFFFFC. `buf_valid` and `frm_drop` are never high together.
- R4: If bit 0 of the fetched address word is 1, `frm_drop` pulses, `stat_bna` is set, nothing is written and `desc_ptr` does not move.
- R5: On `frm_end`, the engine writes the status word at `desc_ptr`+4. Bits 10:0 hold the stored length, bits 31:23 hold `frm_class[8:0]` (bit 8 lands in bit 31, bit 0 in bit 23), and bits 22:11 are 0.
- R6: After the status write, the engine rewrites the address word with bit 0 set and bits 31:1 unchanged, and sets `stat_rec`.
- R7: After a descriptor is completed, `desc_ptr` becomes `ring_base` if its bit 1 was set, and otherwise advances by 8.
- R8: After MAX_DESC consecutive descriptors with no wrap bit, `desc_ptr` returns to `ring_base`.
- R9: A `frm_len` above BUF_BYTES (default 1536) is stored as BUF_BYTES and sets `stat_ovr`. A length equal to BUF_BYTES is stored unchanged and does not set `stat_ovr`.
- R10: While `rx_enable` is 0, `desc_ptr` equals `ring_base` one cycle later, `frm_start` is ignored, and any frame in progress is abandoned with no writeback.
- R11: Each status flag stays set until its `stat_clr` bit is pulsed (bit 0 clears rec, bit 1 clears bna, bit 2 clears ovr). Clearing one flag leaves the others unchanged.
- R12: A memory request keeps `mem_addr` and `mem_wdata` stable until `mem_ack`.
- R13: A `frm_start` that arrives while `busy` is 1 is ignored; no further fetch follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Reception enable; low resets to ring base |
| ring_base | input | 32 | Ring base address (8-byte aligned) |
| frm_start | input | 1 | Pulse: a frame begins |
| frm_end | input | 1 | Pulse: frame complete, length and class valid |
| frm_len | input | LEN_W | Received frame length in bytes |
| frm_class | input | 9 | Address-match classification bits |
| buf_valid | output | 1 | Pulse: buffer granted |
| buf_addr | output | 32 | Granted buffer pointer |
| frm_drop | output | 1 | Pulse: frame dropped, no free descriptor |
| busy | output | 1 | Engine is handling a frame |
| desc_ptr | output | 32 | Current descriptor address |
| stat_clr | input | 3 | Per-flag clear pulses |
| stat_rec | output | 1 | Sticky frame-received flag |
| stat_bna | output | 1 | Sticky buffer-not-available flag |
| stat_ovr | output | 1 | Sticky overrun flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions rely on four conditions at the inputs:
- `ring_base` is 8-byte aligned and holds steady while reception is enabled.
- `mem_ack` pulses once per request and only while `mem_req` is high.
- `frm_end` follows a buffer grant.
- The request-stability check assumes `rx_enable` stays high during a request.

The bench meets these conditions as follows. It keeps the base constant, and its memory model answers each request once after a random wait of zero to two cycles. It ends a frame only after `buf_valid`. It lowers `rx_enable` only while the engine waits for the end of a frame, when no request is open.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_FILL  = 3'd2,
    ST_WSTAT = 3'd3,
    ST_WOWN  = 3'd4
  } rxr_state_e;

  localparam int unsigned CLASS_W     = 9;
  localparam int unsigned LEN_FIELD_W = 11;
  localparam int unsigned OWN_BIT     = 0;
  localparam int unsigned WRAP_BIT    = 1;
  localparam int unsigned NUM_FLAGS   = 3;
  localparam int unsigned DESC_BYTES  = 8;
  localparam int unsigned STAT_OFS    = 4;
endpackage

// File: rtl/rxr_ptr.sv
module rxr_ptr #(
  parameter int unsigned MAX_DESC = 1024
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        rx_enable,
  input  logic [31:0] ring_base,
  input  logic        adv,
  input  logic        wrap_flag,
  output logic [31:0] desc_ptr
);
  import rxr_pkg::*;

  localparam int unsigned IDX_W = (MAX_DESC > 2) ? $clog2(MAX_DESC) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_DESC - 1);

  logic [31:0]      ptr_q, ptr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ptr_en;
  logic             to_base;

  always_comb begin
    to_base = wrap_flag || (idx_q == LAST_IDX);
    ptr_en  = !rx_enable || adv;
    ptr_d   = ptr_q;
    idx_d   = idx_q;
    if (!rx_enable) begin
      ptr_d = ring_base;
      idx_d = '0;
    end else if (adv) begin
      if (to_base) begin
        ptr_d = ring_base;
        idx_d = '0;
      end else begin
        ptr_d = ptr_q + 32'(DESC_BYTES);
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      idx_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
      idx_q <= idx_d;
    end
  end

  assign desc_ptr = ptr_q;

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_enable && adv && wrap_flag) |=> (desc_ptr == $past(ring_base)));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_enable && adv && !wrap_flag && idx_q != LAST_IDX)
      |=> (desc_ptr == $past(desc_ptr) + 32'(DESC_BYTES)));

  assert_ring_limit_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_enable && adv && idx_q == LAST_IDX) |=> (desc_ptr == $past(ring_base)));
endmodule

// File: rtl/rxr_stat.sv
module rxr_stat (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic [rxr_pkg::NUM_FLAGS-1:0] set_i,
  input  logic [rxr_pkg::NUM_FLAGS-1:0] clr_i,
  output logic [rxr_pkg::NUM_FLAGS-1:0] flags
);
  import rxr_pkg::*;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic f_q, f_d, f_en;

    always_comb begin
      f_en = set_i[g] || clr_i[g];
      f_d  = set_i[g];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) f_q <= 1'b0;
      else if (f_en) f_q <= f_d;
    end

    assign flags[g] = f_q;

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_ni)
      (flags[g] && !clr_i[g]) |=> flags[g]);

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flags[g]);
  end
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq #(
  parameter int unsigned BUF_BYTES = 1536,
  parameter int unsigned LEN_W     = 14
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        rx_enable,
  input  logic                        frm_start,
  input  logic                        frm_end,
  input  logic [LEN_W-1:0]            frm_len,
  input  logic [rxr_pkg::CLASS_W-1:0] frm_class,
  input  logic [31:0]                 desc_ptr,
  input  logic                        mem_ack,
  input  logic [31:0]                 mem_rdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [31:0]                 mem_addr,
  output logic [31:0]                 mem_wdata,
  output logic                        buf_valid,
  output logic [31:0]                 buf_addr,
  output logic                        frm_drop,
  output logic                        busy,
  output logic                        adv,
  output logic                        wrap_flag,
  output logic                        set_rec,
  output logic                        set_bna,
  output logic                        set_ovr
);
  import rxr_pkg::*;

  localparam logic [LEN_W-1:0]       CAP_LEN   = LEN_W'(BUF_BYTES);
  localparam logic [LEN_FIELD_W-1:0] CAP_FIELD = LEN_FIELD_W'(BUF_BYTES);
  localparam int unsigned            CLASS_LSB = 32 - CLASS_W;

  rxr_state_e st_q, st_d;
  logic [31:0] word0_q, word0_d, stat_q, stat_d;
  logic        ovr_q, ovr_d;
  logic        bv_q, bv_d, drop_q, drop_d;
  logic        word0_en, stat_en;
  logic        len_over;
  logic [LEN_FIELD_W-1:0] len_fld;
  logic        in_mem;
  logic        ack_ok;

  always_comb begin
    len_over = frm_len > CAP_LEN;
    len_fld  = len_over ? CAP_FIELD : frm_len[LEN_FIELD_W-1:0];
    in_mem   = (st_q == ST_FETCH) || (st_q == ST_WSTAT) || (st_q == ST_WOWN);
    mem_req  = in_mem && rx_enable;
    ack_ok   = mem_req && mem_ack;

    st_d      = st_q;
    word0_d   = mem_rdata;
    word0_en  = 1'b0;
    stat_d    = '0;
    stat_en   = 1'b0;
    ovr_d     = len_over;
    bv_d      = 1'b0;
    drop_d    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = '0;
    adv       = 1'b0;
    wrap_flag = word0_q[WRAP_BIT];
    set_rec   = 1'b0;
    set_bna   = 1'b0;
    set_ovr   = 1'b0;

    stat_d[31:CLASS_LSB]     = frm_class;
    stat_d[LEN_FIELD_W-1:0]  = len_fld;

    case (st_q)
      ST_IDLE: begin
        if (frm_start) st_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (ack_ok) begin
          if (mem_rdata[OWN_BIT]) begin
            drop_d  = 1'b1;
            set_bna = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            word0_en = 1'b1;
            bv_d     = 1'b1;
            st_d     = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (frm_end) begin
          stat_en = 1'b1;
          st_d    = ST_WSTAT;
        end
      end
      ST_WSTAT: begin
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + 32'(STAT_OFS);
        mem_wdata = stat_q;
        if (ack_ok) st_d = ST_WOWN;
      end
      ST_WOWN: begin
        mem_we    = 1'b1;
        mem_wdata = word0_q | 32'h1;
        if (ack_ok) begin
          adv     = 1'b1;
          set_rec = 1'b1;
          set_ovr = ovr_q;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (!rx_enable) begin
      st_d     = ST_IDLE;
      bv_d     = 1'b0;
      drop_d   = 1'b0;
      word0_en = 1'b0;
      stat_en  = 1'b0;
      adv      = 1'b0;
      set_rec  = 1'b0;
      set_bna  = 1'b0;
      set_ovr  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bv_q   <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bv_q   <= bv_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word0_q <= '0;
    end else if (word0_en) begin
      word0_q <= word0_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ovr_q  <= 1'b0;
    end else if (stat_en) begin
      stat_q <= stat_d;
      ovr_q  <= ovr_d;
    end
  end

  assign buf_valid = bv_q;
  assign frm_drop  = drop_q;
  assign buf_addr  = {word0_q[31:2], 2'b00};
  assign busy      = (st_q != ST_IDLE);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=>
      (!rx_enable || (mem_req && $stable(mem_addr) && $stable(mem_wdata))));

  assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && mem_we && mem_addr == desc_ptr + 32'(STAT_OFS))
      |-> (mem_wdata[LEN_FIELD_W-1:0] <= CAP_FIELD));

  assert_grant_excl_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({buf_valid, frm_drop}));

  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && frm_start && rx_enable) |=> (mem_req && !mem_we));
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine #(
  parameter int unsigned MAX_DESC  = 1024,
  parameter int unsigned BUF_BYTES = 1536,
  parameter int unsigned LEN_W     = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic [31:0]      ring_base,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [8:0]       frm_class,
  output logic             buf_valid,
  output logic [31:0]      buf_addr,
  output logic             frm_drop,
  output logic             busy,
  output logic [31:0]      desc_ptr,
  input  logic [2:0]       stat_clr,
  output logic             stat_rec,
  output logic             stat_bna,
  output logic             stat_ovr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata
);
  import rxr_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       adv, wrap_flag;
  logic       set_rec, set_bna, set_ovr;
  logic [NUM_FLAGS-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rxr_ptr #(.MAX_DESC(MAX_DESC)) u_ptr (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .rx_enable (rx_enable),
    .ring_base (ring_base),
    .adv       (adv),
    .wrap_flag (wrap_flag),
    .desc_ptr  (desc_ptr)
  );

  rxr_seq #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .rx_enable (rx_enable),
    .frm_start (frm_start),
    .frm_end   (frm_end),
    .frm_len   (frm_len),
    .frm_class (frm_class),
    .desc_ptr  (desc_ptr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .buf_valid (buf_valid),
    .buf_addr  (buf_addr),
    .frm_drop  (frm_drop),
    .busy      (busy),
    .adv       (adv),
    .wrap_flag (wrap_flag),
    .set_rec   (set_rec),
    .set_bna   (set_bna),
    .set_ovr   (set_ovr)
  );

  rxr_stat u_stat (
    .clk    (clk),
    .rst_ni (rst_ni),
    .set_i  ({set_ovr, set_bna, set_rec}),
    .clr_i  (stat_clr),
    .flags  (flags)
  );

  assign stat_rec = flags[0];
  assign stat_bna = flags[1];
  assign stat_ovr = flags[2];

  assert_drop_flag_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    frm_drop |-> stat_bna);

  assert_drop_still_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (frm_drop && rx_enable) |-> (desc_ptr == $past(desc_ptr)));

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !rx_enable |=> (desc_ptr == $past(ring_base) && !busy));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_ni |-> (!busy && !mem_req && !stat_rec && !stat_bna && !stat_ovr));
endmodule

// File: tb/test_rxring_engine.sv
module test_rxring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD       = 8;
  localparam int LW         = 14;
  localparam int CAP        = 1536;
  localparam logic [31:0] BASE = 32'h0000_0200;
  localparam int WB         = 128;

  logic clk = 1'b0;
  logic rst_n, rx_enable, frm_start, frm_end, buf_valid, frm_drop, busy;
  logic [LW-1:0] frm_len;
  logic [8:0]  frm_class;
  logic [31:0] buf_addr, desc_ptr, mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  stat_clr;
  logic stat_rec, stat_bna, stat_ovr, mem_req, mem_we, mem_ack;

  logic [31:0] mem [0:255];
  int nchk = 0, nfail = 0;
  int exp_idx = 0, ring_len = 4;
  bit ring_wrap = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxring_engine #(.MAX_DESC(MAXD), .BUF_BYTES(CAP), .LEN_W(LW)) i_rxring_engine (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(BASE),
    .frm_start(frm_start), .frm_end(frm_end), .frm_len(frm_len), .frm_class(frm_class),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .frm_drop(frm_drop), .busy(busy),
    .desc_ptr(desc_ptr), .stat_clr(stat_clr), .stat_rec(stat_rec), .stat_bna(stat_bna),
    .stat_ovr(stat_ovr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] widx(input int i);
    return 8'(WB + 2 * i);
  endfunction

  function automatic logic [31:0] bufa(input int i);
    return 32'h0001_0000 + 32'(i) * 32'h600;
  endfunction

  function automatic logic [31:0] dptr(input int i);
    return BASE + 32'(8 * i);
  endfunction

  function automatic int next_idx(input int i);
    if ((ring_wrap && i == ring_len - 1) || i == MAXD - 1) return 0;
    return i + 1;
  endfunction

  function automatic logic [31:0] exp_stat(input int len, input logic [8:0] cls);
    logic [31:0] w;
    w = '0;
    w[31:23] = cls;
    w[10:0]  = (len > CAP) ? 11'(CAP) : 11'(len);
    return w;
  endfunction

  // memory model: answers each request once after 0..2 waits
  initial begin : mem_model
    logic [31:0] held_a, held_d;
    int wcnt;
    bit open;
    mem_ack = 1'b0; mem_rdata = '0; open = 1'b0; wcnt = 0;
    held_a = '0; held_d = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (!open) begin
          open = 1'b1; held_a = mem_addr; held_d = mem_wdata;
          wcnt = int'($urandom % 3);
        end
        if (wcnt == 0) begin
          check(mem_addr == held_a && mem_wdata == held_d, "R12", mem_addr, held_a);
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[9:2]];
          mem_ack = 1'b1;
          open = 1'b0;
        end else begin
          wcnt--;
        end
      end else begin
        open = 1'b0;
      end
    end
  end

  task automatic setup_ring(input int n, input bit wrap);
    ring_len = n; ring_wrap = wrap;
    for (int i = 0; i < n; i++) begin
      mem[widx(i)]     = bufa(i) | ((wrap && i == n - 1) ? 32'h2 : 32'h0);
      mem[widx(i) + 1] = '0;
    end
  endtask

  task automatic restart();
    @(negedge clk) rx_enable = 1'b0;
    @(negedge clk);
    check(desc_ptr == BASE && !busy, "R10", desc_ptr, BASE);
    rx_enable = 1'b1;
    exp_idx = 0;
  endtask

  task automatic do_frame(input int len, input logic [8:0] cls, input bit dup, input bit rel);
    int idx;
    logic [31:0] w0;
    bit owned;
    idx = exp_idx;
    w0 = mem[widx(idx)];
    owned = w0[0];
    @(negedge clk) stat_clr = 3'b111;
    @(negedge clk) stat_clr = 3'b000; frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    check(mem_req && !mem_we && mem_addr == dptr(idx), "R2", mem_addr, dptr(idx));
    for (int k = 0; k < 40; k++) begin
      if (buf_valid || frm_drop) break;
      @(negedge clk);
    end
    if (owned) begin
      check(frm_drop && !buf_valid, "R4", {30'd0, frm_drop, buf_valid}, 32'h2);
      check(stat_bna, "R4", 32'(stat_bna), 32'h1);
      @(negedge clk);
      check(desc_ptr == dptr(idx) && !busy, "R4", desc_ptr, dptr(idx));
      check(mem[widx(idx)] == w0, "R4", mem[widx(idx)], w0);
      return;
    end
    check(buf_valid && buf_addr == (w0 & 32'hFFFF_FFFC), "R3", buf_addr, w0 & 32'hFFFF_FFFC);
    if (dup) begin
      frm_start = 1'b1;
      @(negedge clk) frm_start = 1'b0;
    end
    frm_end = 1'b1; frm_len = LW'(len); frm_class = cls;
    @(negedge clk) frm_end = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check(mem[widx(idx) + 1] == exp_stat(len, cls), "R5", mem[widx(idx) + 1], exp_stat(len, cls));
    check(mem[widx(idx)] == (w0 | 32'h1), "R6", mem[widx(idx)], w0 | 32'h1);
    check(stat_rec, "R6", 32'(stat_rec), 32'h1);
    check(stat_ovr == (len > CAP), "R9", 32'(stat_ovr), 32'(len > CAP));
    exp_idx = next_idx(idx);
    if (idx == MAXD - 1 && !w0[1])
      check(desc_ptr == dptr(exp_idx), "R8", desc_ptr, dptr(exp_idx));
    else
      check(desc_ptr == dptr(exp_idx), "R7", desc_ptr, dptr(exp_idx));
    if (dup) begin
      repeat (3) @(negedge clk);
      check(!busy && !mem_req, "R13", {30'd0, busy, mem_req}, 32'h0);
    end
    if (rel) mem[widx(idx)][0] = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] saved;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; rx_enable = 1'b0; frm_start = 1'b0; frm_end = 1'b0;
    frm_len = '0; frm_class = '0; stat_clr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !mem_req && !buf_valid && !frm_drop, "R1", {28'd0, busy, mem_req, buf_valid, frm_drop}, 32'h0);
    check(!stat_rec && !stat_bna && !stat_ovr, "R1", {29'd0, stat_ovr, stat_bna, stat_rec}, 32'h0);
    check(desc_ptr == BASE, "R10", desc_ptr, BASE);
    frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    @(negedge clk);
    check(!busy && !mem_req, "R10", {30'd0, busy, mem_req}, 32'h0);
    rx_enable = 1'b1;

    // four-entry ring, wrap bit on last; fill without returning
    setup_ring(4, 1'b1);
    do_frame(64, 9'h100, 1'b0, 1'b0);
    do_frame(CAP, 9'h0AA, 1'b0, 1'b0);
    do_frame(CAP + 1, 9'h155, 1'b0, 1'b0);
    do_frame(2000, 9'h1FF, 1'b0, 1'b0);
    check(desc_ptr == BASE, "R7", desc_ptr, BASE);
    do_frame(80, 9'h001, 1'b0, 1'b0);

    // sticky flags: bna remains after a rec clear
    @(negedge clk) stat_clr = 3'b001;
    @(negedge clk) stat_clr = 3'b000;
    check(!stat_rec && stat_bna, "R11", {30'd0, stat_bna, stat_rec}, 32'h2);
    repeat (3) @(negedge clk);
    check(stat_bna, "R11", 32'(stat_bna), 32'h1);
    stat_clr = 3'b010;
    @(negedge clk) stat_clr = 3'b000;
    check(!stat_bna, "R11", 32'(stat_bna), 32'h0);

    for (int i = 0; i < 4; i++) mem[widx(i)][0] = 1'b0;
    restart();
    do_frame(100, 9'h042, 1'b1, 1'b1);

    for (int n = 0; n < 30; n++)
      do_frame(int'($urandom % 2047) + 1, 9'($urandom), 1'b0, 1'b1);

    // abort in the middle of a frame
    saved = mem[widx(exp_idx) + 1];
    @(negedge clk) frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (buf_valid) break;
      @(negedge clk);
    end
    rx_enable = 1'b0;
    @(negedge clk);
    check(!busy && desc_ptr == BASE, "R10", desc_ptr, BASE);
    repeat (4) @(negedge clk);
    check(mem[widx(exp_idx) + 1] == saved && !mem_req, "R10", mem[widx(exp_idx) + 1], saved);
    rx_enable = 1'b1;
    exp_idx = 0;

    // eight entries and no wrap bit: ring limit brings it home
    setup_ring(MAXD, 1'b0);
    restart();
    for (int n = 0; n < MAXD + 3; n++)
      do_frame(int'($urandom % 1500) + 60, 9'($urandom), 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule